// File: doc/BRIEF.md
# Floating-Point Control and Status Register

This block is the 32-bit control and status word of a scalar floating-point unit. It holds the rounding mode, the flush-to-zero control and eight comparison condition codes. It also holds a five-bit enable mask, five sticky exception flags and a six-bit cause field that records what the most recent arithmetic operation raised. Software reads and writes the whole word through a single port. Compare instructions set or clear individual condition codes through per-code strobes. The arithmetic datapath reports the exceptions of each completed operation on a dedicated input.

The condition codes are not stored in one contiguous run: code 0 sits just below the flush control bit and codes 1 to 7 sit just above it. The block therefore also provides a packed byte with code n in bit n, for branch logic. From the stored word it drives the rounding mode, the flush control and a trap request. All updates take effect at the rising clock edge, and every output is a direct function of the stored word.

Top module: `fpcsr_unit`

## Requirements
- R1: A synchronous active-high reset clears all 32 bits, so every output reads zero afterwards.
- R2: A software write stores all 32 bits of `sw_wdata`, and `sw_rdata` returns the stored word from the following cycle.
- R3: `cc_set[n]` sets condition code n. Code 0 is bit 23 and code n (1..7) is bit 24+n. No other bit changes.
- R4: `cc_clr[n]` clears condition code n at the same position and changes no other bit. When set and clear strobe the same code in one cycle, the code ends up set.
- R5: `cc_packed` carries code 0 in bit 0 and codes 1..7 in bits 7:1, each following its stored bit.
- R6: An exception report replaces the cause field (bits 17:12) with `exc_bits`. The weights are 1 inexact, 2 underflow, 4 overflow, 8 divide-by-zero, 16 invalid and 32 unimplemented.
- R7: The same report ORs `exc_bits[4:0]` into the sticky flags (bits 6:2). A report never clears a flag and never places the unimplemented bit in the flags.
- R8: A software write in the same cycle as a report or strobes wins: the stored word equals the written data.
- R9: `round_mode` is bits 1:0 and `flush_zero` is bit 24. Condition code strobes and reports never change bit 24.
- R10: `trap_req` is high when a cause bit among bits 16:12 has its matching enable bit (bits 11:7, same weight order) set, or when cause bit 17 (unimplemented) is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sw_we | input | 1 | Software write strobe |
| sw_wdata | input | 32 | Software write data |
| sw_rdata | output | 32 | Stored register word |
| cc_set | input | 8 | Per-code set strobes from compare instructions |
| cc_clr | input | 8 | Per-code clear strobes from compare instructions |
| cc_packed | output | 8 | Condition codes repacked, code n in bit n |
| exc_valid | input | 1 | Exception report strobe from the datapath |
| exc_bits | input | 6 | Reported exceptions, weighted as in R6 |
| round_mode | output | 2 | Rounding mode selection |
| flush_zero | output | 1 | Flush-to-zero control |
| trap_req | output | 1 | Enabled or unimplemented exception pending |

## Verification
The two functions most likely to collide are a condition code strobe from a compare and an exception report from the datapath. Both modify disjoint fields of the same word in one cycle. The bench drives both in one cycle, with a software write added on top in another cycle. It judges the outcome from the full word read back and from the packed byte. In the combined case every touched field must reflect its own update, and with the write present only the written data may survive. The scoreboard also checks that the flush bit stays untouched across these collisions.

// File: rtl/fpcsr_pkg.sv
package fpcsr_pkg;

    localparam int CSR_W  = 32;
    localparam int CC_NUM = 8;
    localparam int EXC_W  = 6;
    localparam int FLG_W  = EXC_W - 1;
    localparam int RM_W   = 2;

    localparam int CC0_POS  = 23;
    localparam int FS_POS   = 24;
    localparam int CCHI_LSB = FS_POS + 1;

    // Stored word, most significant field first.
    typedef struct packed {
        logic [CC_NUM-2:0] cc_hi;   // codes 7..1
        logic              fs;      // flush-to-zero
        logic              cc0;     // code 0
        logic [4:0]        spare;
        logic [EXC_W-1:0]  cause;
        logic [FLG_W-1:0]  enable;
        logic [FLG_W-1:0]  flags;
        logic [RM_W-1:0]   rm;
    } csr_t;

    // Bit position of condition code n inside the stored word.
    function automatic int cc_pos(input int n);
        return (n == 0) ? CC0_POS : (FS_POS + n);
    endfunction

endpackage

// File: rtl/fpcsr_cc_unit.sv
module fpcsr_cc_unit
    import fpcsr_pkg::*;
(
    input  logic [CSR_W-1:0]  word_in,
    input  logic [CC_NUM-1:0] set_i,
    input  logic [CC_NUM-1:0] clr_i,
    output logic [CSR_W-1:0]  word_out,
    output logic [CC_NUM-1:0] packed_o
);

    logic [CC_NUM-1:0] cc_cur;
    logic [CC_NUM-1:0] cc_nxt;

    for (genvar n = 0; n < CC_NUM; n++) begin : g_cc
        localparam int P = cc_pos(n);
        assign cc_cur[n]   = word_in[P];
        // set dominates clear
        assign cc_nxt[n]   = set_i[n] | (cc_cur[n] & ~clr_i[n]);
        assign packed_o[n] = cc_cur[n];
    end

    always_comb begin
        word_out = word_in;
        for (int n = 0; n < CC_NUM; n++) begin
            word_out[cc_pos(n)] = cc_nxt[n];
        end
    end

endmodule

// File: rtl/fpcsr_exc_merge.sv
module fpcsr_exc_merge
    import fpcsr_pkg::*;
(
    input  csr_t             word_in,
    input  logic             valid_i,
    input  logic [EXC_W-1:0] bits_i,
    output csr_t             word_out
);

    always_comb begin
        word_out = word_in;
        if (valid_i) begin
            word_out.cause = bits_i;
            word_out.flags = word_in.flags | bits_i[FLG_W-1:0];
        end
    end

endmodule

// File: rtl/fpcsr_trap.sv
module fpcsr_trap
    import fpcsr_pkg::*;
(
    input  logic [EXC_W-1:0] cause_i,
    input  logic [FLG_W-1:0] enable_i,
    output logic             trap_o
);

    assign trap_o = (|(cause_i[FLG_W-1:0] & enable_i)) | cause_i[EXC_W-1];

endmodule

// File: rtl/fpcsr_unit.sv
module fpcsr_unit
    import fpcsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sw_we,
    input  logic [CSR_W-1:0]  sw_wdata,
    output logic [CSR_W-1:0]  sw_rdata,
    input  logic [CC_NUM-1:0] cc_set,
    input  logic [CC_NUM-1:0] cc_clr,
    output logic [CC_NUM-1:0] cc_packed,
    input  logic              exc_valid,
    input  logic [EXC_W-1:0]  exc_bits,
    output logic [RM_W-1:0]   round_mode,
    output logic              flush_zero,
    output logic              trap_req
);

    csr_t             csr_q;
    logic [CSR_W-1:0] after_cc;
    csr_t             after_exc;

    fpcsr_cc_unit u_cc (
        .word_in  (csr_q),
        .set_i    (cc_set),
        .clr_i    (cc_clr),
        .word_out (after_cc),
        .packed_o (cc_packed)
    );

    fpcsr_exc_merge u_exc (
        .word_in  (csr_t'(after_cc)),
        .valid_i  (exc_valid),
        .bits_i   (exc_bits),
        .word_out (after_exc)
    );

    fpcsr_trap u_trap (
        .cause_i  (csr_q.cause),
        .enable_i (csr_q.enable),
        .trap_o   (trap_req)
    );

    always_ff @(posedge clk) begin
        if (rst)        csr_q <= '0;
        else if (sw_we) csr_q <= csr_t'(sw_wdata);
        else            csr_q <= after_exc;
    end

    assign sw_rdata   = csr_q;
    assign round_mode = csr_q.rm;
    assign flush_zero = csr_q.fs;

    // R8: software write wins over everything in its cycle
    a_r8_sw_priority: assert property (@(posedge clk) disable iff (rst)
        sw_we |=> (sw_rdata == $past(sw_wdata)));

    // R6: a report without a write loads the cause field
    a_r6_cause_load: assert property (@(posedge clk) disable iff (rst)
        (!sw_we && exc_valid) |=> (csr_q.cause == $past(exc_bits)));

    // R7: flags only accumulate unless software writes
    a_r7_flags_sticky: assert property (@(posedge clk) disable iff (rst)
        !sw_we |=> ((csr_q.flags & $past(csr_q.flags)) == $past(csr_q.flags)));

    // R9: only a software write moves the flush control
    a_r9_flush_hold: assert property (@(posedge clk) disable iff (rst)
        !sw_we |=> $stable(flush_zero));

    // R10: no cause, no trap
    a_r10_no_cause_no_trap: assert property (@(posedge clk) disable iff (rst)
        (csr_q.cause == '0) |-> !trap_req);

endmodule

// File: tb/tb_fpcsr_unit.sv
`timescale 1ns/1ps
module tb_fpcsr_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sw_we = 1'b0;
    logic [31:0] sw_wdata = '0;
    logic [31:0] sw_rdata;
    logic [7:0]  cc_set = '0;
    logic [7:0]  cc_clr = '0;
    logic [7:0]  cc_packed;
    logic        exc_valid = 1'b0;
    logic [5:0]  exc_bits = '0;
    logic [1:0]  round_mode;
    logic        flush_zero;
    logic        trap_req;

    always #2.5 clk = ~clk;

    fpcsr_unit dut (
        .clk(clk), .rst(rst), .sw_we(sw_we), .sw_wdata(sw_wdata),
        .sw_rdata(sw_rdata), .cc_set(cc_set), .cc_clr(cc_clr),
        .cc_packed(cc_packed), .exc_valid(exc_valid), .exc_bits(exc_bits),
        .round_mode(round_mode), .flush_zero(flush_zero), .trap_req(trap_req)
    );

    // {word, packed, rm, fs, trap}
    logic [43:0] exp_q[$];
    string       tag_q[$];
    int          n_vec = 0;
    int          n_bad = 0;
    bit          done  = 0;
    logic [31:0] m;

    function automatic logic [43:0] expect_of(input logic [31:0] w);
        logic [7:0] pk;
        logic       tr;
        pk = {w[31:25], w[23]};
        tr = (|(w[16:12] & w[11:7])) | w[17];
        return {w, pk, w[1:0], w[24], tr};
    endfunction

    task automatic step(input logic we, input logic [31:0] wd,
                        input logic [7:0] st, input logic [7:0] cl,
                        input logic ev, input logic [5:0] eb, input string tag);
        @(negedge clk);
        sw_we = we; sw_wdata = wd; cc_set = st; cc_clr = cl;
        exc_valid = ev; exc_bits = eb;
        if (we) m = wd;
        else begin
            for (int n = 0; n < 8; n++) begin
                int p;
                p = (n == 0) ? 23 : 24 + n;
                if (st[n]) m[p] = 1'b1;
                else if (cl[n]) m[p] = 1'b0;
            end
            if (ev) begin
                m[17:12] = eb;
                m[6:2]   = m[6:2] | eb[4:0];
            end
        end
        @(posedge clk);
        #1;
        sw_we = 0; cc_set = '0; cc_clr = '0; exc_valid = 0;
        exp_q.push_back(expect_of(m));
        tag_q.push_back(tag);
    endtask

    task automatic idle(input string tag);
        step(0, '0, '0, '0, 0, '0, tag);
    endtask

    // monitor
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [43:0] e;
            logic [43:0] a;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            a = {sw_rdata, cc_packed, round_mode, flush_zero, trap_req};
            n_vec++;
            if (a !== e) begin
                n_bad++;
                $display("FAIL %s: actual word=%h pk=%h rm=%b fs=%b trap=%b expected word=%h pk=%h rm=%b fs=%b trap=%b",
                         t, a[43:12], a[11:4], a[3:2], a[1], a[0],
                         e[43:12], e[11:4], e[3:2], e[1], e[0]);
            end
        end
    end

    initial begin
        #(5 * 20000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual not finished expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        m = '0;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        idle("R1 reset state");

        // R2 full-word write and readback
        step(1, 32'hA5A5_5A5A, '0, '0, 0, '0, "R2 write pattern A");
        idle("R2 hold pattern A");
        step(1, 32'hFFFF_FFFF, '0, '0, 0, '0, "R2 write all ones");

        // R4 clear single codes from all ones; R9 bit 24 stays
        step(0, '0, '0, 8'h01, 0, '0, "R4 clear cc0");
        step(0, '0, '0, 8'h80, 0, '0, "R4 clear cc7");
        step(0, '0, 8'h08, 8'h08, 0, '0, "R4 set beats clear cc3");

        // R3/R5 walk set across every code from zero
        step(1, 32'h0, '0, '0, 0, '0, "R2 write zero");
        for (int n = 0; n < 8; n++) begin
            step(0, '0, 8'(1 << n), '0, 0, '0, $sformatf("R3 R5 set cc%0d", n));
        end
        step(0, '0, '0, 8'h55, 0, '0, "R4 R5 clear even codes");

        // R9 rounding mode and flush control
        step(1, 32'h0100_0003, '0, '0, 0, '0, "R9 rm=3 flush=1");
        step(0, '0, 8'hFF, '0, 0, '0, "R9 strobes leave flush");
        step(0, '0, '0, 8'hFF, 1, 6'h3F, "R9 report and clears leave flush");
        step(1, 32'h0000_0002, '0, '0, 0, '0, "R9 rm=2 flush=0");

        // R6/R7 reports
        step(1, 32'h0, '0, '0, 0, '0, "R2 clear before reports");
        step(0, '0, '0, '0, 1, 6'b000101, "R6 R7 inexact+overflow");
        step(0, '0, '0, '0, 1, 6'b100010, "R6 R7 underflow+unimpl");
        step(0, '0, '0, '0, 1, 6'b000000, "R7 empty report keeps flags");
        idle("R7 idle keeps flags");

        // same-cycle collision: compare strobe with report
        step(0, '0, 8'h42, '0, 1, 6'b011000, "R3 R6 R7 cc strobe with report");

        // R8 software write wins
        step(1, 32'h1234_5678, 8'hFF, 8'h00, 1, 6'h3F, "R8 write over report and sets");
        step(1, 32'h0000_0000, 8'h00, 8'hFF, 1, 6'h01, "R8 write over report and clears");

        // R10 trap
        step(1, 32'h0000_0200, '0, '0, 0, '0, "R10 enable overflow only");
        step(0, '0, '0, '0, 1, 6'b000100, "R10 enabled overflow traps");
        step(0, '0, '0, '0, 1, 6'b000001, "R10 disabled inexact no trap");
        step(0, '0, '0, '0, 1, 6'b100000, "R10 unimplemented always traps");
        step(1, 32'h0000_0F80, '0, '0, 0, '0, "R10 all enables");
        step(0, '0, '0, '0, 1, 6'b010000, "R10 invalid traps");

        // R1 reset mid-run
        step(1, 32'hDEAD_BEEF, '0, '0, 0, '0, "R2 write before reset");
        @(negedge clk); rst = 1;
        @(posedge clk); #1 rst = 0;
        m = '0;
        idle("R1 reset clears word");

        repeat (3) @(posedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule